// File: doc/BRIEF.md
# Edge-Polarity GPIO Port Controller

This block is a general-purpose pin port with a 16-bit register interface. Every pin has three things: a direction bit, an output latch and an edge-select bit. The edge-select bit makes the pin's interrupt fire on either a rising or a falling transition.

Pin inputs pass through a two-flop synchronizer. An edge is found by comparing the synchronized value with a registered copy from the cycle before. An edge that qualifies sets a sticky status bit. A single interrupt line stays high while any status bit is set. Software clears status bits by writing ones to them.

Output latch values reach a pin only where that pin is configured as an output. Reads of the synchronized inputs are gated by a separate pin-enable register. The bus is a simple strobe interface with a combinational read path. Only half-word (16-bit) accesses have any effect.

Top module: `pinport_ctrl`

## Requirements
- R1: After reset, the output latch, direction, edge-select, mask and pin-enable registers read 0xFFFF. The status register and the input register read 0x0000, and `irq` is low.
- R2: A direction bit of 1 makes the pin an input and a 0 makes it an output. `pin_oe` is the inverse of the direction register. `pin_out` carries the output latch bit where the pin is an output and 0 elsewhere. Both follow a register write from the first clock edge after it.
- R3: A status bit is set only for a pin that is an input and whose mask bit is 0. An edge-select bit of 1 catches a 0-to-1 transition and a 0 catches a 1-to-0 transition. Transitions of the other polarity, of masked pins and of output pins are ignored.
- R4: Writing the status register clears each bit written as 1 and leaves the others. `irq` is high exactly while at least one status bit is set.
- R5: Reading offset 0x00 returns the synchronized pin values ANDed with the pin-enable register.
- R6: A pin change shows in the input register after two clock edges. The status bit and `irq` follow on the third clock edge after the change.
- R7: An access takes effect only when `bus_size` is 2'b01 (16-bit). A write of any other size changes nothing, and a read of any other size returns 0.
- R8: Writes to offset 0x00 (input register) have no effect. Reads of an unmapped offset return 0, and writes to one are ignored.
- R9: When a new edge event and a status-clear write hit the same bit in the same cycle, the bit ends up set.
- R10: The register offsets are: 0x00 inputs, 0x04 output latch, 0x08 direction, 0x0C edge select, 0x10 mask, 0x14 status, 0x18 pin enable. Every writable register reads back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_addr | input | 8 | Byte offset of the register |
| bus_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data, valid while bus_rd is high |
| pin_in | input | NPINS | Asynchronous pin inputs |
| pin_out | output | NPINS | Driven pin values (0 where not an output) |
| pin_oe | output | NPINS | Output enable per pin (1 = driving) |
| irq | output | 1 | Sticky interrupt, high while any status bit is set |

## Verification
Register writes take effect on the clock edge that samples the strobe. The bench therefore checks outputs that depend on register state at the falling edge after that write. Read data is combinational, so it is sampled shortly after the read strobe is driven.

A pin change is driven on a falling edge. The input register is checked one falling edge later, where it must still show the old value, and again two falling edges later, where it must show the new one. `irq` is checked to be low two falling edges after the change and high three falling edges after it.

For the same-cycle event-and-clear case, the clear write is launched so that it is sampled on the very edge that latches the event.

// File: rtl/pinport_pkg.sv
// Package: shared constants and types for the pin port controller.
// Assumes an 8-bit byte-offset register space and half-word data.
package pinport_pkg;

    localparam int REG_AW = 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    localparam logic [REG_AW-1:0] OFS_DIN  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_DOUT = 8'h04;
    localparam logic [REG_AW-1:0] OFS_DIR  = 8'h08;
    localparam logic [REG_AW-1:0] OFS_EDGE = 8'h0C;
    localparam logic [REG_AW-1:0] OFS_MASK = 8'h10;
    localparam logic [REG_AW-1:0] OFS_STAT = 8'h14;
    localparam logic [REG_AW-1:0] OFS_PCTL = 8'h18;

endpackage

// File: rtl/pinport_sync.sv
// Module: pinport_sync
// Synchronizes the asynchronous pin inputs through two flops, keeps a
// one-cycle-old copy, and produces a per-pin edge hit of the polarity
// chosen by edge_sel (1 = rising, 0 = falling).
// Assumes pin_in may change at any time relative to clk.
module pinport_sync #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] edge_sel,
    output logic [NPINS-1:0] sync_o,
    output logic [NPINS-1:0] hit_o
);

    logic [NPINS-1:0] s1_q;
    logic [NPINS-1:0] s2_q;
    logic [NPINS-1:0] prev_q;

    // Two-stage synchronizer plus the previous-cycle copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            s2_q   <= '0;
            prev_q <= '0;
        end else begin
            s1_q   <= pin_in;
            s2_q   <= s1_q;
            prev_q <= s2_q;
        end
    end

    // Per-pin polarity selection of the detected transition.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise;
        logic fall;
        assign rise     = s2_q[i] & ~prev_q[i];
        assign fall     = ~s2_q[i] & prev_q[i];
        assign hit_o[i] = edge_sel[i] ? rise : fall;
    end

    assign sync_o = s2_q;

endmodule

// File: rtl/pinport_regs.sv
// Module: pinport_regs
// Holds the writable configuration registers: output latch, direction,
// edge select, mask and pin enable. It also turns a write to the status
// offset into a clear vector.
// Assumes wr_ok already includes the access-size check.
module pinport_regs
    import pinport_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [REG_AW-1:0] addr,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  out_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  edge_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  pctl_q,
    output logic [NPINS-1:0]  stat_clr
);

    // Register file update; the input, status and unmapped offsets are not stored here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '1;
            dir_q  <= '1;
            edge_q <= '1;
            mask_q <= '1;
            pctl_q <= '1;
        end else if (wr_ok) begin
            case (addr)
                OFS_DOUT: out_q  <= wdata;
                OFS_DIR:  dir_q  <= wdata;
                OFS_EDGE: edge_q <= wdata;
                OFS_MASK: mask_q <= wdata;
                OFS_PCTL: pctl_q <= wdata;
                default:  ;
            endcase
        end
    end

    // Write-one-to-clear vector for the status register.
    always_comb begin
        stat_clr = '0;
        if (wr_ok && addr == OFS_STAT) begin
            stat_clr = wdata;
        end
    end

endmodule

// File: rtl/pinport_irq.sv
// Module: pinport_irq
// Latches qualified edge hits into sticky status bits. The bits are cleared
// by a write-one vector. It drives a level interrupt while any bit is set.
// Assumes a new hit outranks a clear of the same bit in the same cycle.
module pinport_irq #(
    parameter int NPINS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] hit,
    input  logic [NPINS-1:0] dir,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] clr,
    output logic [NPINS-1:0] status_q,
    output logic             irq
);

    logic [NPINS-1:0] event_v;

    // Qualify hits: input pins only, unmasked pins only.
    assign event_v = hit & dir & ~mask;

    // Sticky status with clear applied before new events are merged in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr) | event_v;
        end
    end

    // Level interrupt from any pending status bit.
    assign irq = |status_q;

endmodule

// File: rtl/pinport_ctrl.sv
// Module: pinport_ctrl (top)
// Edge-polarity GPIO port: the register interface, the output drive and
// the interrupt. Reads are combinational and gated by bus_rd and a legal size.
// Assumes one access per strobe cycle and NPINS <= bus data width.
module pinport_ctrl
    import pinport_pkg::*;
#(
    parameter int NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    logic             size_ok;
    logic             wr_ok;
    logic [NPINS-1:0] out_q;
    logic [NPINS-1:0] dir_q;
    logic [NPINS-1:0] edge_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] pctl_q;
    logic [NPINS-1:0] stat_clr;
    logic [NPINS-1:0] status_q;
    logic [NPINS-1:0] sync_v;
    logic [NPINS-1:0] hit;

    // Only half-word accesses are honoured.
    assign size_ok = (bus_size == SZ_HALF);
    assign wr_ok   = bus_wr & size_ok;

    pinport_sync #(.NPINS(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .edge_sel (edge_q),
        .sync_o   (sync_v),
        .hit_o    (hit)
    );

    pinport_regs #(.NPINS(NPINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ok    (wr_ok),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .out_q    (out_q),
        .dir_q    (dir_q),
        .edge_q   (edge_q),
        .mask_q   (mask_q),
        .pctl_q   (pctl_q),
        .stat_clr (stat_clr)
    );

    pinport_irq #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .dir      (dir_q),
        .mask     (mask_q),
        .clr      (stat_clr),
        .status_q (status_q),
        .irq      (irq)
    );

    // Pin drive: the latch reaches a pin only where direction is 0.
    assign pin_oe  = ~dir_q;
    assign pin_out = out_q & ~dir_q;

    // Combinational read mux; zero for illegal size or unmapped offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && size_ok) begin
            case (bus_addr)
                OFS_DIN:  bus_rdata = sync_v & pctl_q;
                OFS_DOUT: bus_rdata = out_q;
                OFS_DIR:  bus_rdata = dir_q;
                OFS_EDGE: bus_rdata = edge_q;
                OFS_MASK: bus_rdata = mask_q;
                OFS_STAT: bus_rdata = status_q;
                OFS_PCTL: bus_rdata = pctl_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/pinport_chk.sv
// Module: pinport_chk
// Assertion checker bound to pinport_ctrl. It observes ports and internal
// register state and checks the timing relations between them.
module pinport_chk
    import pinport_pkg::*;
#(
    parameter int NPINS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [REG_AW-1:0] bus_addr,
    input logic [1:0]        bus_size,
    input logic [NPINS-1:0]  bus_wdata,
    input logic              irq,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe,
    input logic [NPINS-1:0]  status_q,
    input logic [NPINS-1:0]  dir_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  out_q,
    input logic [NPINS-1:0]  hit
);

    logic             clr_wr;
    logic [NPINS-1:0] qual;

    assign clr_wr = bus_wr && (bus_size == SZ_HALF) && (bus_addr == OFS_STAT);
    assign qual   = hit & dir_q & ~mask_q;

    AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~pin_oe) == '0); // R2

    AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q & ~$past(status_q) & ~($past(dir_q) & ~$past(mask_q))) == '0); // R3

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_wr) |=> irq); // R4

    AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && bus_wdata == '1 && qual == '0) |=> (status_q == '0)); // R4

    AST_BADSIZE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_size != SZ_HALF) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q))); // R7

    AST_DIN_READONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_DIN) |=> ($stable(out_q) && $stable(dir_q) && $stable(mask_q))); // R8

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && qual != '0) |=> ((status_q & $past(qual)) == $past(qual))); // R9

endmodule

bind pinport_ctrl pinport_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .status_q  (status_q),
    .dir_q     (dir_q),
    .mask_q    (mask_q),
    .out_q     (out_q),
    .hit       (hit)
);

// File: tb/sim_pinport_ctrl.sv
// Bench for pinport_ctrl: a vector table walked by one loop, then directed
// tests for pin timing, edge polarity, clearing, collisions and reset.
module sim_pinport_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NVEC       = 17;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [1:0]  bus_size = 2'b01;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = 16'h0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pinport_ctrl #(.NPINS(16)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_size  (bus_size),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    // Row: {is_write, offset, write data, expected read data}
    localparam logic [40:0] VEC [0:NVEC-1] = '{
        {1'b0, 8'h04, 16'h0000, 16'hFFFF},  // R1 output latch
        {1'b0, 8'h08, 16'h0000, 16'hFFFF},  // R1 direction
        {1'b0, 8'h0C, 16'h0000, 16'hFFFF},  // R1 edge select
        {1'b0, 8'h10, 16'h0000, 16'hFFFF},  // R1 mask
        {1'b0, 8'h18, 16'h0000, 16'hFFFF},  // R1 pin enable
        {1'b0, 8'h14, 16'h0000, 16'h0000},  // R1 status
        {1'b0, 8'h00, 16'h0000, 16'h0000},  // R1 inputs
        {1'b1, 8'h04, 16'hA5C3, 16'h0000},
        {1'b0, 8'h04, 16'h0000, 16'hA5C3},  // R10
        {1'b1, 8'h18, 16'hFF00, 16'h0000},
        {1'b0, 8'h18, 16'h0000, 16'hFF00},  // R10
        {1'b1, 8'h0C, 16'hFFDF, 16'h0000},
        {1'b0, 8'h0C, 16'h0000, 16'hFFDF},  // R10
        {1'b1, 8'h20, 16'h1234, 16'h0000},
        {1'b0, 8'h20, 16'h0000, 16'h0000},  // R8 unmapped
        {1'b1, 8'h10, 16'h0080, 16'h0000},
        {1'b0, 8'h10, 16'h0000, 16'h0080}   // R10
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, input logic [1:0] sz);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        bus_size  = sz;
        @(negedge clk);
        bus_wr   = 1'b0;
        bus_size = 2'b01;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] d);
        @(negedge clk);
        bus_rd   = 1'b1;
        bus_addr = a;
        bus_size = sz;
        #1;
        d        = bus_rdata;
        bus_rd   = 1'b0;
        bus_size = 2'b01;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] rd;
        idle(3);
        rst_n = 1'b1;

        chk("R1 irq after reset", {15'h0, irq}, 16'h0);
        chk("R1 pin_oe after reset", pin_oe, 16'h0000);

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][40]) begin
                bus_write(VEC[i][39:32], VEC[i][31:16], 2'b01);
            end else begin
                bus_read(VEC[i][39:32], 2'b01, rd);
                chk($sformatf("R1/R8/R10 table row %0d", i), rd, VEC[i][15:0]);
            end
        end

        // R7: wrong-size write ignored, wrong-size read returns zero.
        bus_write(8'h04, 16'h0000, 2'b10);
        bus_read(8'h04, 2'b01, rd);
        chk("R7 word write ignored", rd, 16'hA5C3);
        bus_read(8'h04, 2'b00, rd);
        chk("R7 byte read zero", rd, 16'h0000);

        // R8: write to input register has no effect.
        bus_write(8'h00, 16'hFFFF, 2'b01);
        bus_read(8'h04, 2'b01, rd);
        chk("R8 input write leaves latch", rd, 16'hA5C3);
        bus_read(8'h08, 2'b01, rd);
        chk("R8 input write leaves direction", rd, 16'hFFFF);

        // R2: drive follows direction changes.
        chk("R2 all inputs no drive", pin_out, 16'h0000);
        bus_write(8'h08, 16'h00FF, 2'b01);
        chk("R2 oe after dir write", pin_oe, 16'hFF00);
        chk("R2 out after dir write", pin_out, 16'hA500);
        bus_write(8'h08, 16'hFDFF, 2'b01);
        bus_write(8'h04, 16'hFFFF, 2'b01);
        chk("R2 only pin9 driven", pin_out, 16'h0200);

        // R5 / R6: input register gated by pin enable, two-edge latency.
        set_pins(16'h0FF0);
        bus_read(8'h00, 2'b01, rd);
        chk("R6 inputs not yet visible", rd, 16'h0000);
        bus_read(8'h00, 2'b01, rd);
        chk("R5 inputs gated by enable", rd, 16'h0F00);
        set_pins(16'h0000);
        idle(4);
        bus_write(8'h14, 16'hFFFF, 2'b01);
        bus_read(8'h14, 2'b01, rd);
        chk("R4 full clear", rd, 16'h0000);
        chk("R4 irq low after clear", {15'h0, irq}, 16'h0);

        // R6 / R3: rising edge on pin3 sets status on the third edge.
        set_pins(16'h0008);
        idle(2);
        chk("R6 irq low after two edges", {15'h0, irq}, 16'h0);
        idle(1);
        chk("R6 irq high after three edges", {15'h0, irq}, 16'h1);
        bus_read(8'h14, 2'b01, rd);
        chk("R3 rising event pin3", rd, 16'h0008);

        // R3: masked pin7, output pin9, falling-only pin5 rising -> no events.
        set_pins(16'h02A8);
        idle(4);
        bus_read(8'h14, 2'b01, rd);
        chk("R3 ignored transitions", rd, 16'h0008);
        set_pins(16'h0288);
        idle(4);
        bus_read(8'h14, 2'b01, rd);
        chk("R3 falling event pin5", rd, 16'h0028);

        // R4: partial clears.
        bus_write(8'h14, 16'h0008, 2'b01);
        bus_read(8'h14, 2'b01, rd);
        chk("R4 clear one bit", rd, 16'h0020);
        chk("R4 irq held by remaining bit", {15'h0, irq}, 16'h1);
        bus_write(8'h14, 16'h0020, 2'b01);
        chk("R4 irq low when empty", {15'h0, irq}, 16'h0);

        // R9: event and clear in the same cycle; event wins.
        set_pins(16'h0280);
        idle(4);
        set_pins(16'h0288);
        idle(4);
        set_pins(16'h02A8);
        idle(4);
        set_pins(16'h0288);
        idle(1);
        bus_write(8'h14, 16'hFFFF, 2'b01);
        bus_read(8'h14, 2'b01, rd);
        chk("R9 event beats clear", rd, 16'h0020);
        chk("R9 irq stays high", {15'h0, irq}, 16'h1);

        // R1: reset in the middle of operation.
        @(negedge clk);
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        chk("R1 irq low after reset", {15'h0, irq}, 16'h0);
        chk("R1 oe after reset", pin_oe, 16'h0000);
        bus_read(8'h04, 2'b01, rd);
        chk("R1 latch after reset", rd, 16'hFFFF);
        bus_read(8'h14, 2'b01, rd);
        chk("R1 status after reset", rd, 16'h0000);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule